// File: doc/BRIEF.md
# Serial Audio Port Transmitter

This block turns parallel audio samples into a two-channel serial stream. Each frame is 64 bit clocks long and holds a left slot of 32 bits and a right slot of 32 bits. The frame clock is low for the left slot and high for the right slot. Two framings are offered: the standard I2S layout, where the first data bit follows the frame-clock edge by one bit clock, and a left-justified layout, where the most significant bit lines up with that edge. Samples arrive right-aligned on a 24-bit bus. A 3-bit size code selects how many of the low bits are sent. They go out most significant bit first, and the rest of the slot is zero. In mono mode one sample is sent in both slots of a frame.

The bit clock and the frame clock can each be generated by the block or taken from outside, so all four master/slave combinations are legal. The core clock `clk_i` runs at twice the master audio clock, so one master-clock period is two core cycles. When the block generates the bit clock, each half period lasts `D+1` core cycles, where `D` is the divider field. The bit period is then `D+1` master-clock periods, and the frame rate is the master clock divided by `64*(D+1)`. External clocks pass through two-flop synchronisers. Serial data always changes after a bit-clock falling edge, and neither clock is ever inverted.

Samples use a valid/ready handshake. `smp_ready_o` is a one-cycle pulse at the start of each slot that needs a new sample: every slot in stereo mode, and only left slots in mono mode. The producer holds `smp_valid_i` and the data steady until the transfer happens.

Top module: `audio_serial_tx`

## Requirements
- R1: While reset is asserted, `bclk_o`, `sdata_o` and `smp_ready_o` are 0, and `fclk_o` is 1 when frame master is selected. The first bit-clock falling edge after reset starts a left slot.
- R2: As bit-clock master, `bclk_o` has a period of 2*(D+1) core cycles, where D is `div_i`. As frame master as well, `fclk_o` has a period of 128*(D+1) core cycles, which is 64 bit clocks.
- R3: With `fmt_msb_i`=0, the sample MSB is in slot bit 1 (the second bit after the frame-clock change). With `fmt_msb_i`=1, it is in slot bit 0.
- R4: Size code 0 sends 8 bits, 1 sends 16, 3 sends 20 and 4 sends 24. The sent bits are the low bits of `smp_data_i`, MSB first, and every other slot bit is 0.
- R5: Size codes 2, 5, 6 and 7 send all-zero slots. Samples are still accepted.
- R6: With `mono_i`=1, one sample is accepted per frame, at the left slot start, and it is sent in both slots.
- R7: With `mono_i`=0, two samples are accepted per frame. The first goes in the left slot, where the frame clock is low, and the second in the right slot. Each slot is 32 bits.
- R8: With `enable_i`=0, `smp_ready_o` stays 0 and every slot sent is all zero.
- R9: With both clocks external, data follows the external bit clock and frame clock. It changes only after a synchronised bit-clock falling edge, and `bclk_o` and `fclk_o` are held at 0.
- R10: In the mixed modes (bit clock generated with frame clock external, and the reverse), samples are framed correctly against the clocks in use. The clock that is not generated is driven 0.
- R11: If `smp_valid_i` is low at a slot start, that slot is sent as zeros, and the waiting sample is not consumed until a later slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Transmit path enable |
| fmt_msb_i | input | 1 | 0 = I2S one-bit delay, 1 = left-justified |
| size_code_i | input | 3 | Sample size code |
| mono_i | input | 1 | Send each sample in both slots |
| bclk_master_i | input | 1 | Block generates the bit clock |
| fclk_master_i | input | 1 | Block generates the frame clock |
| div_i | input | DIV_W | Divider field D, half bit period = D+1 core cycles |
| smp_valid_i | input | 1 | Sample available |
| smp_data_i | input | SAMPLE_W | Right-aligned sample |
| smp_ready_o | output | 1 | Sample accepted this cycle when valid |
| bclk_ext_i | input | 1 | External bit clock |
| fclk_ext_i | input | 1 | External frame clock |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions assume that configuration inputs change only while the block is held in reset. They also assume that each external bit-clock half period lasts well over three core cycles, and that the external frame clock changes only near a bit-clock falling edge, so the synchronised copies are settled at the next rising edge. The stimulus changes formats, directions and the divider only under reset. It drives the external bit clock with six-cycle half periods and toggles the external frame clock right after every 32nd falling edge. The serial stream is decoded by a receiver model that samples on the rising edge of whichever bit clock is active.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int SLOT_BITS  = 32;
  localparam int IDX_W      = $clog2(SLOT_BITS);
  localparam int CNT_W      = IDX_W + 1;
  localparam int WIDTH_W    = IDX_W + 2;

  // Size code to number of sample bits; unused codes map to zero.
  function automatic logic [WIDTH_W-1:0] size_to_width(input logic [2:0] code);
    case (code)
      3'd0:    size_to_width = WIDTH_W'(8);
      3'd1:    size_to_width = WIDTH_W'(16);
      3'd3:    size_to_width = WIDTH_W'(20);
      3'd4:    size_to_width = WIDTH_W'(24);
      default: size_to_width = '0;
    endcase
  endfunction
endpackage

// File: rtl/asp_clkgen.sv
module asp_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bclk_ext_i,
  input  logic             fclk_ext_i,
  output logic             bit_fall_o,
  output logic             bit_rise_o,
  output logic             bclk_o,
  output logic             fclk_smp_o
);
  logic [DIV_W-1:0] hc_q, hc_n;
  logic             bclk_q, bclk_n;
  logic [2:0]       bsync_q, bsync_n;
  logic [1:0]       fsync_q, fsync_n;
  logic             half_done, m_fall, m_rise, s_fall, s_rise;

  always_comb begin
    half_done = (hc_q >= div_i);
    hc_n      = half_done ? '0 : hc_q + 1'b1;
    bclk_n    = half_done ? ~bclk_q : bclk_q;
    bsync_n   = {bsync_q[1:0], bclk_ext_i};
    fsync_n   = {fsync_q[0], fclk_ext_i};
    m_fall    = half_done & bclk_q;
    m_rise    = half_done & ~bclk_q;
    s_fall    = bsync_q[2] & ~bsync_q[1];
    s_rise    = ~bsync_q[2] & bsync_q[1];
    bit_fall_o = bclk_master_i ? m_fall : s_fall;
    bit_rise_o = bclk_master_i ? m_rise : s_rise;
    bclk_o     = bclk_master_i & bclk_q;
    fclk_smp_o = fsync_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q    <= '0;
      bclk_q  <= 1'b0;
      bsync_q <= '0;
      fsync_q <= '0;
    end else begin
      hc_q    <= hc_n;
      bclk_q  <= bclk_n;
      bsync_q <= bsync_n;
      fsync_q <= fsync_n;
    end
  end

  // Generated bit clock only moves when a half period completes.
  assert_bclk_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc_q < div_i) |=> $stable(bclk_q));
  // Synchronised external edges never collide and never repeat back to back.
  assert_edge_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_rise_o, bit_fall_o}));
  assert_slave_fall_spaced_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bclk_master_i && s_fall) |=> !s_fall);
endmodule

// File: rtl/asp_framer.sv
module asp_framer
  import asp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fclk_master_i,
  input  logic             bit_fall_i,
  input  logic             bit_rise_i,
  input  logic             fclk_smp_i,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic             fclk_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ws_cap_q, ws_cap_n;
  logic             ws_last_q, ws_last_n;

  always_comb begin
    cnt_n     = cnt_q;
    ws_cap_n  = ws_cap_q;
    ws_last_n = ws_last_q;
    if (bit_rise_i) ws_cap_n = fclk_smp_i;
    if (bit_fall_i) begin
      ws_last_n = ws_cap_q;
      // External frame edge seen one bit late: realign to slot bit 1.
      if (!fclk_master_i && (ws_cap_q != ws_last_q))
        cnt_n = {ws_cap_q, IDX_W'(1)};
      else
        cnt_n = cnt_q + 1'b1;
    end
    cnt_n_o = cnt_n;
    fclk_o  = fclk_master_i & cnt_q[CNT_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      ws_cap_q  <= 1'b0;
      ws_last_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      ws_cap_q  <= ws_cap_n;
      ws_last_q <= ws_last_n;
    end
  end

  // Frame position advances only on bit-clock falling events.
  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_fall_i |=> $stable(cnt_q));
  assert_fclk_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_fall_i && $stable(fclk_master_i)) |=> (!fclk_master_i || $stable(fclk_o)));
endmodule

// File: rtl/asp_shifter.sv
module asp_shifter
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_fall_i,
  input  logic [CNT_W-1:0]    cnt_n_i,
  input  logic                enable_i,
  input  logic                fmt_msb_i,
  input  logic [2:0]          size_code_i,
  input  logic                mono_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                smp_ready_o,
  output logic                sdata_o
);
  localparam int SHW = WIDTH_W + 1;

  logic [SLOT_BITS-1:0] word_q, word_n, aligned, image;
  logic                 sdata_q, sdata_n;
  logic [WIDTH_W-1:0]   width;
  logic [SHW-1:0]       shamt;
  logic [IDX_W-1:0]     slot_idx;
  logic                 slot_start, need, take;

  always_comb begin
    width      = size_to_width(size_code_i);
    shamt      = SHW'(SLOT_BITS) - SHW'(width);
    aligned    = SLOT_BITS'(smp_data_i) << shamt;
    slot_idx   = cnt_n_i[IDX_W-1:0];
    slot_start = bit_fall_i && (slot_idx == '0);
    need       = !cnt_n_i[CNT_W-1] || !mono_i;
    smp_ready_o = enable_i && slot_start && need;
    take       = smp_ready_o && smp_valid_i;
    word_n     = word_q;
    if (slot_start && need) word_n = take ? aligned : '0;
    image      = fmt_msb_i ? word_n : {1'b0, word_n[SLOT_BITS-1:1]};
    sdata_n    = bit_fall_i ? image[~slot_idx] : sdata_q;
    sdata_o    = sdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      sdata_q <= 1'b0;
    end else begin
      word_q  <= word_n;
      sdata_q <= sdata_n;
    end
  end

  assert_data_after_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_fall_i |=> $stable(sdata_o));
  assert_mono_left_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_ready_o && mono_i) |-> !cnt_n_i[CNT_W-1]);
  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (size_code_i inside {3'd2, 3'd5, 3'd6, 3'd7})) |=> (word_q == '0));
  assert_underrun_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start && need && !smp_valid_i) |=> (word_q == '0));
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import asp_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                fmt_msb_i,
  input  logic [2:0]          size_code_i,
  input  logic                mono_i,
  input  logic                bclk_master_i,
  input  logic                fclk_master_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                smp_ready_o,
  input  logic                bclk_ext_i,
  input  logic                fclk_ext_i,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic                sdata_o
);
  logic             bit_fall, bit_rise, fclk_smp;
  logic [CNT_W-1:0] cnt_n;

  asp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bclk_master_i (bclk_master_i),
    .div_i         (div_i),
    .bclk_ext_i    (bclk_ext_i),
    .fclk_ext_i    (fclk_ext_i),
    .bit_fall_o    (bit_fall),
    .bit_rise_o    (bit_rise),
    .bclk_o        (bclk_o),
    .fclk_smp_o    (fclk_smp)
  );

  asp_framer u_framer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fclk_master_i (fclk_master_i),
    .bit_fall_i    (bit_fall),
    .bit_rise_i    (bit_rise),
    .fclk_smp_i    (fclk_smp),
    .cnt_n_o       (cnt_n),
    .fclk_o        (fclk_o)
  );

  asp_shifter #(.SAMPLE_W(SAMPLE_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_fall_i  (bit_fall),
    .cnt_n_i     (cnt_n),
    .enable_i    (enable_i),
    .fmt_msb_i   (fmt_msb_i),
    .size_code_i (size_code_i),
    .mono_i      (mono_i),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .smp_ready_o (smp_ready_o),
    .sdata_o     (sdata_o)
  );

  // Outputs of a clock the block does not generate stay low.
  assert_slave_outputs_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bclk_master_i |-> !bclk_o) and (!fclk_master_i |-> !fclk_o));
  assert_ready_needs_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_ready_o |-> bit_fall);
endmodule

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n, enable, fmt_msb, mono, bclk_mst, fclk_mst;
  logic [2:0]  size_code;
  logic [3:0]  div;
  logic        smp_valid, bclk_ext, fclk_ext;
  logic [23:0] smp_data;
  logic        smp_ready, bclk_o, fclk_o, sdata;

  always #2 clk = ~clk;

  audio_serial_tx u_audio_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .fmt_msb_i(fmt_msb),
    .size_code_i(size_code), .mono_i(mono), .bclk_master_i(bclk_mst),
    .fclk_master_i(fclk_mst), .div_i(div), .smp_valid_i(smp_valid),
    .smp_data_i(smp_data), .smp_ready_o(smp_ready), .bclk_ext_i(bclk_ext),
    .fclk_ext_i(fclk_ext), .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata)
  );

  // {fmt_msb, size_code, mono, div}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 3'd1, 1'b0, 4'd0},
    {1'b1, 3'd1, 1'b0, 4'd1},
    {1'b0, 3'd4, 1'b1, 4'd0},
    {1'b1, 3'd0, 1'b0, 4'd2},
    {1'b0, 3'd3, 1'b0, 4'd0},
    {1'b1, 3'd4, 1'b1, 4'd1}
  };
  localparam logic [23:0] CONST_SMP = 24'hC3A55A;

  int n_chk = 0, n_fail = 0;
  int smp_idx, xfer_cnt, ext_cnt, ext_bits, fbits;
  logic xfer_pend, cmode, ext_run, fgen_run, bo_prev;

  // Receiver model
  logic        rx_on, rx_prev, rx_started;
  logic [31:0] rx_word;
  logic [31:0] slots [16];
  logic        slv [16];
  int          rx_n;
  wire bclk_obs = bclk_mst ? bclk_o : bclk_ext;
  wire fclk_obs = fclk_mst ? fclk_o : fclk_ext;

  function automatic logic [23:0] pat(input int i);
    return 24'h9A5C3E ^ 24'(i * 24'h01B3D7);
  endfunction

  function automatic logic [31:0] exp_slot(input logic [23:0] s, input logic [2:0] code,
                                           input logic msb);
    int w;
    logic [31:0] v;
    case (code)
      3'd0: w = 8; 3'd1: w = 16; 3'd3: w = 20; 3'd4: w = 24; default: w = 0;
    endcase
    v = '0;
    for (int b = 0; b < w; b++) v[31-b] = s[w-1-b];
    if (!msb) v = v >> 1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge bclk_obs) begin
    if (rx_on) begin
      if (fclk_obs != rx_prev) begin
        if (rx_started && rx_n < 16) begin
          slots[rx_n] = rx_word;
          slv[rx_n]   = rx_prev;
          rx_n++;
        end
        rx_started = 1'b1;
        rx_word = '0;
      end
      rx_prev = fclk_obs;
      rx_word = {rx_word[30:0], sdata};
    end
  end

  always @(negedge clk) begin
    if (xfer_pend) begin smp_idx++; xfer_pend = 1'b0; end
    if (smp_valid && smp_ready) begin xfer_pend = 1'b1; xfer_cnt++; end
    smp_data = cmode ? CONST_SMP : pat(smp_idx);
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt == 6) begin
        ext_cnt = 0;
        if (bclk_ext) begin
          bclk_ext = 1'b0;
          ext_bits++;
          if (ext_bits == 32) begin ext_bits = 0; fclk_ext = ~fclk_ext; end
        end else bclk_ext = 1'b1;
      end
    end
    if (fgen_run) begin
      if (!bclk_o && bo_prev) begin
        fbits++;
        if (fbits == 32) begin fbits = 0; fclk_ext = ~fclk_ext; end
      end
      bo_prev = bclk_o;
    end
  end

  task automatic start(input logic f_msb, input logic [2:0] code, input logic mo,
                       input logic [3:0] d, input logic bm, input logic fm,
                       input logic en, input logic vld, input logic cm);
    @(negedge clk);
    rst_n = 1'b0;
    rx_on = 1'b0; ext_run = 1'b0; fgen_run = 1'b0;
    fmt_msb = f_msb; size_code = code; mono = mo; div = d;
    bclk_mst = bm; fclk_mst = fm; enable = en; smp_valid = vld; cmode = cm;
    bclk_ext = 1'b0; fclk_ext = 1'b0;
    repeat (3) @(negedge clk);
    smp_idx = 0; xfer_cnt = 0; xfer_pend = 1'b0;
    ext_cnt = 0; ext_bits = 0; fbits = 0; bo_prev = 1'b0;
    rx_n = 0; rx_started = 1'b0; rx_word = '0; rx_prev = 1'b1;
    for (int i = 0; i < 16; i++) begin slots[i] = '0; slv[i] = 1'b0; end
    rx_on = 1'b1;
    ext_run = !bm;
    fgen_run = bm && !fm;
    rst_n = 1'b1;
  endtask

  task automatic wait_slots(input int n, input string req);
    int lim;
    lim = 0;
    while (rx_n < n && lim < 20000) begin @(negedge clk); lim++; end
    chk({req, " slot count"}, 32'(rx_n >= n), 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t0, t1, k;
    logic pv;
    rst_n = 1'b0; enable = 1'b0; fmt_msb = 1'b0; size_code = 3'd1; mono = 1'b0;
    bclk_mst = 1'b1; fclk_mst = 1'b1; div = 4'd0; smp_valid = 1'b0;
    bclk_ext = 1'b0; fclk_ext = 1'b0; cmode = 1'b0; rx_on = 1'b0;
    ext_run = 1'b0; fgen_run = 1'b0; xfer_pend = 1'b0; smp_idx = 0; xfer_cnt = 0;
    smp_data = '0; rx_n = 0; rx_started = 1'b0; rx_prev = 1'b1; rx_word = '0;
    bo_prev = 1'b0; ext_cnt = 0; ext_bits = 0; fbits = 0;

    // R1: values held during reset
    repeat (3) @(negedge clk);
    chk("R1 bclk_o", 32'(bclk_o), 32'd0);
    chk("R1 fclk_o", 32'(fclk_o), 32'd1);
    chk("R1 sdata_o", 32'(sdata), 32'd0);
    chk("R1 smp_ready_o", 32'(smp_ready), 32'd0);

    // Vector table: master clocks, varied format, size, mono, divider
    for (int v = 0; v < 6; v++) begin
      logic [8:0] c;
      int idx;
      c = VEC[v];
      start(c[8], c[7:5], c[4], c[3:0], 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      wait_slots(5, "R7");
      for (int s = 0; s < 4; s++) begin
        idx = c[4] ? s / 2 : s;
        chk(c[4] ? "R6 R3 R4 slot" : "R7 R3 R4 slot", slots[s],
            exp_slot(pat(idx), c[7:5], c[8]));
      end
      chk("R7 left slot frame clock low", 32'(slv[0]), 32'd0);
      chk("R7 right slot frame clock high", 32'(slv[1]), 32'd1);
    end

    // R2: bit and frame periods with divider field 3
    start(1'b0, 3'd1, 1'b0, 4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    k = 0; t0 = 0; t1 = 0; pv = bclk_o;
    for (int i = 0; i < 100 && k < 2; i++) begin
      @(negedge clk);
      if (bclk_o && !pv) begin if (k == 0) t0 = i; else t1 = i; k++; end
      pv = bclk_o;
    end
    chk("R2 bit clock period", 32'(t1 - t0), 32'd8);
    k = 0; pv = fclk_o;
    for (int i = 0; i < 2000 && k < 2; i++) begin
      @(negedge clk);
      if (!fclk_o && pv) begin if (k == 0) t0 = i; else t1 = i; k++; end
      pv = fclk_o;
    end
    chk("R2 frame clock period", 32'(t1 - t0), 32'd512);

    // R8: transmit disabled
    start(1'b1, 3'd4, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    wait_slots(5, "R8");
    chk("R8 no transfers", 32'(xfer_cnt), 32'd0);
    for (int s = 0; s < 4; s++) chk("R8 zero slot", slots[s], 32'd0);

    // R11: producer not ready
    start(1'b1, 3'd1, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    wait_slots(5, "R11");
    chk("R11 no transfers", 32'(xfer_cnt), 32'd0);
    for (int s = 0; s < 4; s++) chk("R11 zero slot", slots[s], 32'd0);

    // R5: unused size code 5
    start(1'b1, 3'd5, 1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    wait_slots(5, "R5");
    chk("R5 samples accepted", 32'(xfer_cnt >= 4), 32'd1);
    for (int s = 0; s < 4; s++) chk("R5 zero slot", slots[s], 32'd0);

    // R9: both clocks external, two framings
    start(1'b0, 3'd1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    wait_slots(7, "R9");
    for (int s = 2; s < 6; s++) chk("R9 slave I2S slot", slots[s], exp_slot(CONST_SMP, 3'd1, 1'b0));
    chk("R9 bclk_o low", 32'(bclk_o), 32'd0);
    chk("R9 fclk_o low", 32'(fclk_o), 32'd0);
    start(1'b1, 3'd4, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    wait_slots(7, "R9");
    for (int s = 2; s < 6; s++) chk("R9 slave MSB slot", slots[s], exp_slot(CONST_SMP, 3'd4, 1'b1));

    // R10: bit clock generated, frame clock external
    start(1'b1, 3'd1, 1'b0, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    wait_slots(7, "R10");
    for (int s = 2; s < 6; s++) chk("R10 bclk master slot", slots[s], exp_slot(CONST_SMP, 3'd1, 1'b1));
    chk("R10 fclk_o low", 32'(fclk_o), 32'd0);

    // R10: bit clock external, frame clock generated
    start(1'b0, 3'd3, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    wait_slots(5, "R10");
    for (int s = 0; s < 4; s++) chk("R10 fclk master slot", slots[s], exp_slot(pat(s), 3'd3, 1'b0));
    chk("R10 bclk_o low", 32'(bclk_o), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule